// File: doc/BRIEF.md
# Flash Programming Command Port

This block is the serial slave through which an external programmer reaches an on-chip flash. It takes a chip select, a serial clock and a data input from the programmer and returns a serial data output. All four pins are oversampled by a fast system clock, so the whole block runs in one clock domain. SPI mode 0 is used: the input bit is taken on the rising serial clock edge, and the output bit changes on the falling edge. Every byte travels most significant bit first.

The block keeps an 8-bit flash status register. Bit 5 of that register is a write-enable latch, and bit 3 of it is an info-page select. Addressed reads go through a one-cycle synchronous read port, which serves either the main array or the info-page array. Flash write and erase operations are not modelled. In their place the block emits a one-cycle strobe, and that strobe is permitted only while the latch is set. The latch drops by itself when the chip select is released after any write or erase command. Each write or erase therefore needs a fresh enable command first.

Top module: `fprog_spi`

## Requirements
- R1: Command 0x06 sets status bit 5, the write-enable latch. Command 0x04 clears that bit. Each of these commands is a single byte.
- R2: While reset is asserted, and directly after it, the status register reads 0x00. The serial output is 0 and neither read enable is active.
- R3: Command 0x02 (write) and command 0x52 (erase) each give one `prog_strobe` pulse when the latch is set, and no pulse when it is clear. `prog_kind` is 0 for write and 1 for erase.
- R4: When the chip select rises after a frame whose command was 0x02 or 0x52, bit 5 clears. This happens whether or not a strobe was given. Frames with other commands leave bit 5 alone.
- R5: Command 0x05 returns the status register on the serial output in the byte that follows it, MSB first. Each bit changes on a falling serial clock edge.
- R6: Command 0x01 loads the following byte into the status register, except for bit 5, which keeps its previous value.
- R7: Command 0x03 is followed by a 16-bit address, sent low byte first with each byte MSB first. Data bytes are then streamed out starting at that address.
- R8: The read address increments after each streamed byte for as long as the chip select stays low. It wraps from 0xFFFF to 0x0000.
- R9: When status bit 3 is 1, reads fetch from the info-page array. When it is 0, reads fetch from the main array. The two enables are never active together.
- R10: An unknown opcode is ignored until the chip select rises. So are any bytes that follow a single-byte command or a status byte.
- R11: A rising chip select resets the bit and byte counters. A partial byte is discarded, and the next frame starts with a fresh command byte.
- R12: Every fetch is a one-cycle enable, and the data is taken on the following cycle. A burst of N data bytes issues N+1 fetches, because the next address is always prefetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Active-low frame select |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from the programmer |
| spi_miso | output | 1 | Serial data to the programmer |
| main_rd_en | output | 1 | One-cycle fetch strobe for the main array |
| info_rd_en | output | 1 | One-cycle fetch strobe for the info-page array |
| mem_rd_addr | output | 16 | Fetch address |
| main_rd_data | input | 8 | Main array data, valid the cycle after the fetch |
| info_rd_data | input | 8 | Info-page data, valid the cycle after the fetch |
| prog_strobe | output | 1 | Placeholder pulse for a permitted write or erase |
| prog_kind | output | 1 | 0 for write, 1 for erase, valid with the strobe |

## Verification
Two things happen in the same register update when a status-write byte completes: eight new status bits are loaded, and the write-enable latch must keep its old value. The bench provokes this by writing 0xFF with the latch clear and 0x00 with the latch set. It judges the result by reading the status back, expecting 0xDF and 0x20. A second case puts a latch change next to a frame end. Here the write or erase frame boundary and the latch clear coincide at the chip-select edge. The bench judges it through the strobe count together with a status read, and it checks a non-programming frame that must leave the latch set.

// File: rtl/fprog_pkg.sv
package fprog_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    localparam int LATCH_BIT = 5;
    localparam int INFO_BIT  = 3;
    localparam logic [DATA_W-1:0] LATCH_MASK = DATA_W'(1) << LATCH_BIT;

    localparam logic [7:0] OP_ENA   = 8'h06;
    localparam logic [7:0] OP_DIS   = 8'h04;
    localparam logic [7:0] OP_RSTAT = 8'h05;
    localparam logic [7:0] OP_WSTAT = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_ERASE = 8'h52;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_STAT_IN,
        PH_ADDR_LO,
        PH_ADDR_HI,
        PH_STREAM,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        phase_t              phase;
        logic [2:0]          bit_cnt;
        logic [DATA_W-2:0]   shin;
        logic [DATA_W-1:0]   tx;
        logic                miso;
        logic [DATA_W-1:0]   stat;
        logic [ADDR_W-1:0]   addr;
        logic                rd_main;
        logic                rd_info;
        logic                load;
        logic                info_sel;
        logic                prog_seen;
        logic                strobe;
        logic                kind;
    } ctrl_state_t;
endpackage

// File: rtl/fprog_sync.sv
module fprog_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [STAGES:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    assign lvl  = chain_q[STAGES-1];
    assign prev = chain_q[STAGES];
endmodule

// File: rtl/fprog_ctrl.sv
module fprog_ctrl
    import fprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              csn_hi,
    input  logic              csn_rise,
    input  logic              mosi,
    input  logic [DATA_W-1:0] main_data,
    input  logic [DATA_W-1:0] info_data,
    output logic              miso,
    output logic              rd_main,
    output logic              rd_info,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              strobe,
    output logic              kind,
    output logic [DATA_W-1:0] status
);
    ctrl_state_t q, d;
    logic [DATA_W-1:0] byte_in;

    assign byte_in = {q.shin, mosi};

    always_comb begin
        d         = q;
        d.strobe  = 1'b0;
        d.rd_main = 1'b0;
        d.rd_info = 1'b0;
        d.load    = q.rd_main | q.rd_info;
        if (q.load) d.tx = q.info_sel ? info_data : main_data;

        if (csn_hi) begin
            d.phase     = PH_CMD;
            d.bit_cnt   = '0;
            d.miso      = 1'b0;
            d.prog_seen = 1'b0;
            if (csn_rise && q.prog_seen) d.stat[LATCH_BIT] = 1'b0;
        end else begin
            if (sck_fall) begin
                d.miso = q.tx[DATA_W-1];
                d.tx   = {q.tx[DATA_W-2:0], 1'b0};
            end
            if (sck_rise) begin
                d.bit_cnt = q.bit_cnt + 3'd1;
                d.shin    = byte_in[DATA_W-2:0];
                if (q.bit_cnt == 3'd7) begin
                    unique case (q.phase)
                        PH_CMD: begin
                            d.phase = PH_SKIP;
                            case (byte_in)
                                OP_ENA:   d.stat[LATCH_BIT] = 1'b1;
                                OP_DIS:   d.stat[LATCH_BIT] = 1'b0;
                                OP_RSTAT: d.tx = q.stat;
                                OP_WSTAT: d.phase = PH_STAT_IN;
                                OP_READ:  d.phase = PH_ADDR_LO;
                                OP_WRITE, OP_ERASE: begin
                                    d.prog_seen = 1'b1;
                                    d.strobe    = q.stat[LATCH_BIT];
                                    d.kind      = (byte_in == OP_ERASE);
                                end
                                default: ;
                            endcase
                        end
                        PH_STAT_IN: begin
                            d.stat  = (byte_in & ~LATCH_MASK) | (q.stat & LATCH_MASK);
                            d.phase = PH_SKIP;
                        end
                        PH_ADDR_LO: begin
                            d.addr[7:0] = byte_in;
                            d.phase     = PH_ADDR_HI;
                        end
                        PH_ADDR_HI: begin
                            d.addr     = {byte_in, q.addr[7:0]};
                            d.phase    = PH_STREAM;
                            d.info_sel = q.stat[INFO_BIT];
                            d.rd_info  = q.stat[INFO_BIT];
                            d.rd_main  = !q.stat[INFO_BIT];
                        end
                        PH_STREAM: begin
                            d.addr     = q.addr + ADDR_W'(1);
                            d.info_sel = q.stat[INFO_BIT];
                            d.rd_info  = q.stat[INFO_BIT];
                            d.rd_main  = !q.stat[INFO_BIT];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_CMD;
        end else begin
            q <= d;
        end
    end

    assign miso    = q.miso;
    assign rd_main = q.rd_main;
    assign rd_info = q.rd_info;
    assign rd_addr = q.addr;
    assign strobe  = q.strobe;
    assign kind    = q.kind;
    assign status  = q.stat;
endmodule

// File: rtl/fprog_spi.sv
module fprog_spi
    import fprog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              main_rd_en,
    output logic              info_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] main_rd_data,
    input  logic [DATA_W-1:0] info_rd_data,
    output logic              prog_strobe,
    output logic              prog_kind
);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0]  pin_lvl, pin_prev;
    logic              csn_lvl;
    logic [DATA_W-1:0] status_w;

    fprog_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_csn, spi_sck, spi_mosi}),
        .lvl  (pin_lvl),
        .prev (pin_prev)
    );

    assign csn_lvl = pin_lvl[2];

    fprog_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (pin_lvl[1] & ~pin_prev[1]),
        .sck_fall (~pin_lvl[1] & pin_prev[1]),
        .csn_hi   (csn_lvl),
        .csn_rise (csn_lvl & ~pin_prev[2]),
        .mosi     (pin_lvl[0]),
        .main_data(main_rd_data),
        .info_data(info_rd_data),
        .miso     (spi_miso),
        .rd_main  (main_rd_en),
        .rd_info  (info_rd_en),
        .rd_addr  (mem_rd_addr),
        .strobe   (prog_strobe),
        .kind     (prog_kind),
        .status   (status_w)
    );
endmodule

// File: rtl/fprog_spi_chk.sv
module fprog_spi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic       csn_lvl,
    input logic       prog_strobe,
    input logic       main_rd_en,
    input logic       info_rd_en,
    input logic       spi_miso
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r2_reset_clear: assert (status == 8'h00 && !spi_miso && !main_rd_en && !info_rd_en);
        end
    end

    a_r1_latch_set_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[5]) |-> $past(!csn_lvl));

    a_r3_strobe_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        prog_strobe |-> status[5]);

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        prog_strobe |=> !prog_strobe);

    a_r9_one_array: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_rd_en && info_rd_en));

    a_r9_info_select: assert property (@(posedge clk) disable iff (!rst_n)
        info_rd_en |-> status[3]);

    a_r9_main_select: assert property (@(posedge clk) disable iff (!rst_n)
        main_rd_en |-> !status[3]);

    a_r12_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rd_en || info_rd_en) |=> !(main_rd_en || info_rd_en));
endmodule

bind fprog_spi fprog_spi_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (status_w),
    .csn_lvl    (csn_lvl),
    .prog_strobe(prog_strobe),
    .main_rd_en (main_rd_en),
    .info_rd_en (info_rd_en),
    .spi_miso   (spi_miso)
);

// File: tb/fprog_spi_bench.sv
module fprog_spi_bench;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic        miso, main_en, info_en, strobe, kind;
    logic [15:0] addr;
    logic [7:0]  main_q = 8'h00, info_q = 8'h00;

    int checks = 0, errors = 0;
    int strobe_cnt = 0, last_kind = 0, main_cnt = 0, info_cnt = 0;

    always #10 clk = ~clk;

    fprog_spi u_fprog_spi (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .main_rd_en(main_en), .info_rd_en(info_en),
        .mem_rd_addr(addr), .main_rd_data(main_q), .info_rd_data(info_q),
        .prog_strobe(strobe), .prog_kind(kind)
    );

    function automatic logic [7:0] main_val(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] info_val(input logic [15:0] a);
        return a[7:0] + 8'(a[15:8] * 3) + 8'h11;
    endfunction

    always @(posedge clk) begin
        if (main_en) main_q <= main_val(addr);
        if (info_en) info_q <= info_val(addr);
    end

    always @(negedge clk) begin
        if (strobe) begin strobe_cnt++; last_kind = int'(kind); end
        if (main_en) main_cnt++;
        if (info_en) info_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_frame();
        csn = 1'b0;
        wclk(HALF);
    endtask

    task automatic end_frame();
        wclk(HALF);
        csn = 1'b1;
        wclk(2 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wclk(HALF);
            rx[i] = miso;
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        begin_frame(); xfer(op, r); end_frame();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] r;
        begin_frame(); xfer(8'h05, r); xfer(8'h00, v); end_frame();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        begin_frame(); xfer(8'h01, r); xfer(v, r); end_frame();
    endtask

    task automatic burst(input logic [15:0] a, input int n, input bit info, input string req);
        logic [7:0] r;
        logic [15:0] cur;
        int m0, i0;
        m0 = main_cnt; i0 = info_cnt;
        begin_frame();
        xfer(8'h03, r); xfer(a[7:0], r); xfer(a[15:8], r);
        for (int k = 0; k < n; k++) begin
            cur = a + 16'(k);
            xfer(8'h00, r);
            if (info) check(r == info_val(cur), req, r, info_val(cur));
            else      check(r == main_val(cur), req, r, main_val(cur));
        end
        end_frame();
        // R12 prefetch: N+1 fetches, only from the selected array
        if (info) check(info_cnt - i0 == n + 1 && main_cnt == m0, "R12", info_cnt - i0, n + 1);
        else      check(main_cnt - m0 == n + 1 && info_cnt == i0, "R12", main_cnt - m0, n + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, r;
        logic [15:0] addrs [5];
        addrs = '{16'h0000, 16'h12FF, 16'h00FF, 16'hABCD, 16'hFFFE};

        wclk(5);
        check(miso == 1'b0 && !main_en && !info_en, "R2", {main_en, info_en, miso}, 0);
        rst_n = 1'b1;
        wclk(5);
        rdsr(v); check(v == 8'h00, "R2", v, 8'h00);

        // R1 enable and disable
        cmd1(8'h06); rdsr(v); check(v == 8'h20, "R1", v, 8'h20);
        rdsr(v); check(v == 8'h20, "R4 status read keeps latch", v, 8'h20);
        cmd1(8'h04); rdsr(v); check(v == 8'h00, "R1", v, 8'h00);

        // R6 / R5 latch kept through status write
        wrsr(8'hFF); rdsr(v); check(v == 8'hDF, "R6", v, 8'hDF);
        cmd1(8'h06); wrsr(8'h00); rdsr(v); check(v == 8'h20, "R6", v, 8'h20);
        wrsr(8'hA5); rdsr(v); check(v == 8'hA5, "R5", v, 8'hA5);
        wrsr(8'h00); cmd1(8'h04);

        // R7 / R8 main reads including carry and wrap
        foreach (addrs[k]) burst(addrs[k], 4, 1'b0, "R7 R8 main");

        // R9 info page
        wrsr(8'h08);
        burst(16'h0040, 3, 1'b1, "R9 info");
        burst(16'hFFFF, 2, 1'b1, "R9 R8 info wrap");
        wrsr(8'h00);
        burst(16'h0040, 2, 1'b0, "R9 back to main");

        // R3 / R4 gated strobe and automatic latch clear
        begin_frame(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h77, r); end_frame();
        check(strobe_cnt == 0, "R3 no latch no strobe", strobe_cnt, 0);
        cmd1(8'h06);
        begin_frame(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h77, r); end_frame();
        check(strobe_cnt == 1 && last_kind == 0, "R3 write", strobe_cnt, 1);
        rdsr(v); check(v[5] == 1'b0, "R4", v, 0);
        cmd1(8'h06);
        begin_frame(); xfer(8'h52, r); xfer(8'h00, r); end_frame();
        check(strobe_cnt == 2 && last_kind == 1, "R3 erase", last_kind, 1);
        rdsr(v); check(v == 8'h00, "R4", v, 8'h00);
        begin_frame(); xfer(8'h52, r); end_frame();
        check(strobe_cnt == 2, "R3 erase without latch", strobe_cnt, 2);

        // R10 unknown opcodes and trailing bytes
        begin_frame(); xfer(8'hAB, r); xfer(8'h06, r); end_frame();
        rdsr(v); check(v == 8'h00, "R10 unknown opcode", v, 8'h00);
        begin_frame(); xfer(8'h06, r); xfer(8'h04, r); end_frame();
        rdsr(v); check(v == 8'h20, "R10 trailing byte", v, 8'h20);

        // R11 aborted partial byte
        csn = 1'b0; wclk(HALF);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b0; wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0;
        end
        end_frame();
        cmd1(8'h04);
        rdsr(v); check(v == 8'h00, "R11", v, 8'h00);
        check(miso == 1'b0, "R11 idle output", miso, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule